// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block gathers the event flags of a real-time clock and merges them onto a single active-low interrupt line. It receives tick strobes from the seconds and minutes counters, an expiry strobe from the countdown timer, and event strobes from the alarm, watchdog, timestamp and battery switch-over logic. It also receives a level input from the battery-low detector. Enable bits and a pulse/level mode bit arrive from the register block. The flags are held here, and software clears them by register writes.

The periodic flag takes its source from two enables. The seconds enable, when set, overrides the minutes enable. The periodic flag and the countdown flag can signal either as a fixed-length pulse or as a level that holds until the flag is cleared. Every other source signals as a level only. The watchdog flag and the battery-low flag cannot be cleared by a write. The first clears when the watchdog is reloaded. The second follows the detector input. When no source is enabled, the output-enable is low, so the pin floats.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: During and right after reset, all flags read 0, `irq_n` is 1 and `irq_oe` is 0.
- R2: The periodic flag (bit 0 of `flags`) is set by `tick_sec` when `en_sec`=1, whatever the value of `en_min`. In that case `tick_min` alone does not set it. With `en_sec`=0 and `en_min`=1, only `tick_min` sets it. With both enables at 0, it never sets.
- R3: While `flag_wr`=1, a 0 in `flag_wdata` clears the writable flags. These are bits 0 (periodic), 1 (countdown), 2 (alarm), 4 (timestamp) and 5 (switch-over). A 1 in `flag_wdata` leaves the bit unchanged. A set event in the same cycle wins over the clear.
- R4: The watchdog flag (bit 3) is set by `wdog_evt` and ignores writes. It clears on `wdog_reload`. A set event in the same cycle wins.
- R5: The battery-low flag (bit 6) equals `batlow_det` as sampled at the previous clock edge, and it ignores writes.
- R6: With `pulse_mode`=0, an enabled periodic or countdown flag drives `irq_n` low one cycle after the flag reads 1. `irq_n` stays low until the cycle after the flag is cleared.
- R7: With `pulse_mode`=1, a set event of the periodic or countdown flag drives `irq_n` low for exactly PULSE_LEN cycles (default 4), starting one cycle after the flag is set. The flag itself stays set.
- R8: The alarm, watchdog, timestamp, switch-over and battery-low sources always act as levels when enabled, whatever the value of `pulse_mode`.
- R9: `irq_oe` is the OR of all enables, registered once. A source whose enable is 0 never pulls `irq_n` low.
- R10: The countdown, alarm, watchdog, timestamp and switch-over flags are set by their events even when their interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | Seconds counter increment strobe |
| tick_min | input | 1 | Minutes counter increment strobe |
| cd_expire | input | 1 | Countdown timer expiry strobe |
| alarm_evt | input | 1 | Alarm match strobe |
| wdog_evt | input | 1 | Watchdog expiry strobe |
| tstamp_evt | input | 1 | Timestamp capture strobe |
| bswitch_evt | input | 1 | Battery switch-over strobe |
| batlow_det | input | 1 | Battery-low detector level |
| wdog_reload | input | 1 | Watchdog reload strobe, clears the watchdog flag |
| en_min | input | 1 | Minute source enable for the periodic flag |
| en_sec | input | 1 | Second source enable for the periodic flag |
| en_cd | input | 1 | Countdown interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_wdog | input | 1 | Watchdog interrupt enable |
| en_tstamp | input | 1 | Timestamp interrupt enable |
| en_bswitch | input | 1 | Switch-over interrupt enable |
| en_batlow | input | 1 | Battery-low interrupt enable |
| pulse_mode | input | 1 | 1: periodic and countdown sources pulse; 0: level |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 7 | Flag write data, 0 clears a writable bit |
| flags | output | 7 | Flag register read value |
| irq_n | output | 1 | Interrupt drive value, 0 when asserted |
| irq_oe | output | 1 | Interrupt pin output-enable |

## Verification
A flag follows its strobe or write at the next clock edge. `irq_n` and `irq_oe` lag the flag state and the enables by one more edge, so an interrupt appears two edges after its event strobe. The bench drives inputs on the falling edge and compares a behavioural model against the outputs on every falling edge. Directed checks read `flags` on the falling edge right after the stimulus and read `irq_n` one cycle later. The pulse checks count the low cycles across a window wider than PULSE_LEN.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int NFLAG = 7;
    // flag bit positions as seen by software
    localparam int F_MS = 0;
    localparam int F_CD = 1;
    localparam int F_AL = 2;
    localparam int F_WD = 3;
    localparam int F_TS = 4;
    localparam int F_BS = 5;
    localparam int F_BL = 6;
    // bits that a write of 0 may clear
    localparam logic [NFLAG-1:0] CLR_MASK = 7'b0110111;
    // sources able to signal as a pulse
    localparam int NPULSE = 2;

    typedef struct packed {
        logic [NFLAG-1:0] flag;
    } flag_st_t;

    typedef struct packed {
        logic irq;
        logic oe;
    } out_st_t;
endpackage

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic             en_sec,
    input  logic             en_min,
    input  logic             cd_expire,
    input  logic             alarm_evt,
    input  logic             wdog_evt,
    input  logic             tstamp_evt,
    input  logic             bswitch_evt,
    input  logic             batlow_det,
    input  logic             wdog_reload,
    input  logic             flag_wr,
    input  logic [NFLAG-1:0] flag_wdata,
    output logic [NFLAG-1:0] flag_q,
    output logic             set_ms,
    output logic             set_cd
);
    flag_st_t st_d, st_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] wclr;

    always_comb begin
        set_vec       = '0;
        // the seconds enable takes priority over the minutes enable
        set_vec[F_MS] = en_sec ? tick_sec : (en_min & tick_min);
        set_vec[F_CD] = cd_expire;
        set_vec[F_AL] = alarm_evt;
        set_vec[F_WD] = wdog_evt;
        set_vec[F_TS] = tstamp_evt;
        set_vec[F_BS] = bswitch_evt;
        wclr          = {NFLAG{flag_wr}} & ~flag_wdata & CLR_MASK;
        st_d          = st_q;
        for (int i = 0; i < NFLAG; i++) begin
            if (i == F_BL) begin
                st_d.flag[i] = batlow_det;
            end else if (i == F_WD) begin
                st_d.flag[i] = (st_q.flag[i] & ~wdog_reload) | set_vec[i];
            end else begin
                st_d.flag[i] = (st_q.flag[i] & ~wclr[i]) | set_vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;
    assign set_ms = set_vec[F_MS];
    assign set_cd = set_vec[F_CD];

    p_sec_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_sec && tick_sec |=> flag_q[F_MS]);
    p_ms_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_sec && !en_min && !flag_q[F_MS] |=> !flag_q[F_MS]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr && !flag_wdata[F_AL] && !alarm_evt |=> !flag_q[F_AL]);
    p_wdog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[F_WD] && !wdog_reload |=> flag_q[F_WD]);
    p_batlow_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_q[F_BL] == $past(batlow_det)));
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.cnt = CW'(PULSE_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PULSE_LEN));
    p_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (st_q.cnt == CW'(PULSE_LEN)));
endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  flag_q,
    input  logic [NFLAG-1:0]  en,
    input  logic [NPULSE-1:0] pulse_act,
    input  logic              pulse_mode,
    output logic              irq_n,
    output logic              irq_oe
);
    out_st_t st_d, st_q;
    logic [NFLAG-1:0] contrib;

    always_comb begin
        contrib = flag_q;
        if (pulse_mode) begin
            contrib[F_MS] = pulse_act[0];
            contrib[F_CD] = pulse_act[1];
        end
        st_d.irq = |(contrib & en);
        st_d.oe  = |en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n  = ~st_q.irq;
    assign irq_oe = st_q.oe;

    p_drive_needs_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.oe);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic             cd_expire,
    input  logic             alarm_evt,
    input  logic             wdog_evt,
    input  logic             tstamp_evt,
    input  logic             bswitch_evt,
    input  logic             batlow_det,
    input  logic             wdog_reload,
    input  logic             en_min,
    input  logic             en_sec,
    input  logic             en_cd,
    input  logic             en_alarm,
    input  logic             en_wdog,
    input  logic             en_tstamp,
    input  logic             en_bswitch,
    input  logic             en_batlow,
    input  logic             pulse_mode,
    input  logic             flag_wr,
    input  logic [NFLAG-1:0] flag_wdata,
    output logic [NFLAG-1:0] flags,
    output logic             irq_n,
    output logic             irq_oe
);
    logic              set_ms, set_cd;
    logic [NPULSE-1:0] ptrig, pact;
    logic [NFLAG-1:0]  en_vec;

    rtc_irq_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_sec    (tick_sec),
        .tick_min    (tick_min),
        .en_sec      (en_sec),
        .en_min      (en_min),
        .cd_expire   (cd_expire),
        .alarm_evt   (alarm_evt),
        .wdog_evt    (wdog_evt),
        .tstamp_evt  (tstamp_evt),
        .bswitch_evt (bswitch_evt),
        .batlow_det  (batlow_det),
        .wdog_reload (wdog_reload),
        .flag_wr     (flag_wr),
        .flag_wdata  (flag_wdata),
        .flag_q      (flags),
        .set_ms      (set_ms),
        .set_cd      (set_cd)
    );

    assign ptrig = {set_cd, set_ms};

    for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
        rtc_irq_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (ptrig[g]),
            .active (pact[g])
        );
    end

    always_comb begin
        en_vec       = '0;
        en_vec[F_MS] = en_min | en_sec;
        en_vec[F_CD] = en_cd;
        en_vec[F_AL] = en_alarm;
        en_vec[F_WD] = en_wdog;
        en_vec[F_TS] = en_tstamp;
        en_vec[F_BS] = en_bswitch;
        en_vec[F_BL] = en_batlow;
    end

    rtc_irq_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_q     (flags),
        .en         (en_vec),
        .pulse_act  (pact),
        .pulse_mode (pulse_mode),
        .irq_n      (irq_n),
        .irq_oe     (irq_oe)
    );
endmodule

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_sec = 0, tick_min = 0, cd_expire = 0, alarm_evt = 0, wdog_evt = 0;
    logic tstamp_evt = 0, bswitch_evt = 0, batlow_det = 0, wdog_reload = 0;
    logic en_min = 0, en_sec = 0, en_cd = 0, en_alarm = 0, en_wdog = 0;
    logic en_tstamp = 0, en_bswitch = 0, en_batlow = 0, pulse_mode = 0;
    logic flag_wr = 0;
    logic [6:0] flag_wdata = '0;
    logic [6:0] flags;
    logic irq_n, irq_oe;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [6:0] m_fl = '0;
    int m_pc0 = 0;
    int m_pc1 = 0;
    logic m_irq = 0;
    logic m_oe = 0;

    always #4 clk = ~clk;

    rtc_irq_ctrl #(.PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .tick_min(tick_min),
        .cd_expire(cd_expire), .alarm_evt(alarm_evt), .wdog_evt(wdog_evt),
        .tstamp_evt(tstamp_evt), .bswitch_evt(bswitch_evt), .batlow_det(batlow_det),
        .wdog_reload(wdog_reload), .en_min(en_min), .en_sec(en_sec), .en_cd(en_cd),
        .en_alarm(en_alarm), .en_wdog(en_wdog), .en_tstamp(en_tstamp),
        .en_bswitch(en_bswitch), .en_batlow(en_batlow), .pulse_mode(pulse_mode),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flags(flags),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_fl = '0; m_pc0 = 0; m_pc1 = 0; m_irq = 0; m_oe = 0;
        end else begin
            logic nirq;
            logic ms_set;
            nirq = 0;
            if ((en_min || en_sec) && (pulse_mode ? (m_pc0 > 0) : m_fl[0])) nirq = 1;
            if (en_cd && (pulse_mode ? (m_pc1 > 0) : m_fl[1])) nirq = 1;
            if (en_alarm && m_fl[2]) nirq = 1;
            if (en_wdog && m_fl[3]) nirq = 1;
            if (en_tstamp && m_fl[4]) nirq = 1;
            if (en_bswitch && m_fl[5]) nirq = 1;
            if (en_batlow && m_fl[6]) nirq = 1;
            m_oe = en_min | en_sec | en_cd | en_alarm | en_wdog | en_tstamp | en_bswitch | en_batlow;
            m_irq = nirq;
            ms_set = en_sec ? tick_sec : (en_min && tick_min);
            if (m_pc0 > 0) m_pc0--;
            if (m_pc1 > 0) m_pc1--;
            if (ms_set) m_pc0 = PL;
            if (cd_expire) m_pc1 = PL;
            if (flag_wr) begin
                if (!flag_wdata[0]) m_fl[0] = 0;
                if (!flag_wdata[1]) m_fl[1] = 0;
                if (!flag_wdata[2]) m_fl[2] = 0;
                if (!flag_wdata[4]) m_fl[4] = 0;
                if (!flag_wdata[5]) m_fl[5] = 0;
            end
            if (wdog_reload) m_fl[3] = 0;
            if (ms_set) m_fl[0] = 1;
            if (cd_expire) m_fl[1] = 1;
            if (alarm_evt) m_fl[2] = 1;
            if (wdog_evt) m_fl[3] = 1;
            if (tstamp_evt) m_fl[4] = 1;
            if (bswitch_evt) m_fl[5] = 1;
            m_fl[6] = batlow_det;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(flags == m_fl, cur_req, "model flags", int'(flags), int'(m_fl));
            chk(irq_n == !m_irq, cur_req, "model irq_n", int'(irq_n), int'(!m_irq));
            chk(irq_oe == m_oe, cur_req, "model irq_oe", int'(irq_oe), int'(m_oe));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input int k);
        @(negedge clk);
        case (k)
            0: tick_sec = 1;
            1: tick_min = 1;
            2: cd_expire = 1;
            3: alarm_evt = 1;
            4: wdog_evt = 1;
            5: tstamp_evt = 1;
            6: bswitch_evt = 1;
            default: wdog_reload = 1;
        endcase
        @(negedge clk);
        tick_sec = 0; tick_min = 0; cd_expire = 0; alarm_evt = 0;
        wdog_evt = 0; tstamp_evt = 0; bswitch_evt = 0; wdog_reload = 0;
    endtask

    task automatic wr(input logic [6:0] v);
        @(negedge clk);
        flag_wr = 1; flag_wdata = v;
        @(negedge clk);
        flag_wr = 0; flag_wdata = '0;
    endtask

    task automatic count_low(input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (!irq_n) n++;
        end
    endtask

    initial begin
        int lows;
        step(2);
        chk(flags == 0 && irq_n == 1 && irq_oe == 0, "R1", "reset outputs",
            int'({flags, irq_n, irq_oe}), 2);
        rst_n = 1;
        step(1);
        chk(flags == 0 && irq_n == 1 && irq_oe == 0, "R1", "after reset",
            int'({flags, irq_n, irq_oe}), 2);

        // periodic flag source selection
        cur_req = "R2";
        fire(0);
        chk(flags[0] == 0, "R2", "sec tick with both enables 0", flags[0], 0);
        en_min = 1;
        fire(0);
        chk(flags[0] == 0, "R2", "sec tick ignored in minute mode", flags[0], 0);
        cur_req = "R6";
        fire(1);
        chk(flags[0] == 1, "R2", "min tick sets flag", flags[0], 1);
        chk(irq_n == 1, "R6", "irq one cycle after flag", irq_n, 1);
        step(1);
        chk(irq_n == 0, "R6", "level irq asserted", irq_n, 0);
        step(5);
        chk(irq_n == 0, "R6", "level irq holds", irq_n, 0);
        cur_req = "R3";
        wr(7'h7F);
        chk(flags[0] == 1, "R3", "write 1 keeps flag", flags[0], 1);
        wr(7'h00);
        chk(flags[0] == 0, "R3", "write 0 clears flag", flags[0], 0);
        step(1);
        chk(irq_n == 1, "R6", "irq released after clear", irq_n, 1);

        cur_req = "R2";
        en_sec = 1;
        fire(1);
        chk(flags[0] == 0, "R2", "min tick ignored when sec enabled", flags[0], 0);
        fire(0);
        chk(flags[0] == 1, "R2", "sec tick sets flag", flags[0], 1);
        wr(7'h00);
        cur_req = "R3";
        @(negedge clk);
        tick_sec = 1; flag_wr = 1; flag_wdata = '0;
        @(negedge clk);
        tick_sec = 0; flag_wr = 0;
        chk(flags[0] == 1, "R3", "set wins over clear", flags[0], 1);
        wr(7'h00);
        step(2);

        // pulsed mode
        cur_req = "R7";
        pulse_mode = 1;
        fire(0);
        count_low(PL + 6, lows);
        chk(lows == PL, "R7", "periodic pulse length", lows, PL);
        chk(flags[0] == 1, "R7", "flag stays after pulse", flags[0], 1);
        wr(7'h00);
        en_min = 0; en_sec = 0;
        en_cd = 1;
        step(2);
        fire(2);
        count_low(PL + 6, lows);
        chk(lows == PL, "R7", "countdown pulse length", lows, PL);
        cur_req = "R6";
        pulse_mode = 0;
        step(2);
        chk(irq_n == 0, "R6", "countdown level in level mode", irq_n, 0);
        wr(7'h00);
        step(1);
        chk(irq_n == 1, "R6", "countdown level cleared", irq_n, 1);
        en_cd = 0;

        // level-only sources ignore pulse mode
        cur_req = "R8";
        pulse_mode = 1; en_alarm = 1;
        fire(3);
        step(PL + 4);
        chk(irq_n == 0, "R8", "alarm stays level in pulse mode", irq_n, 0);
        wr(7'h00);
        step(1);
        chk(irq_n == 1, "R8", "alarm released after clear", irq_n, 1);
        en_alarm = 0; pulse_mode = 0;

        // watchdog flag
        cur_req = "R4";
        en_wdog = 1;
        fire(4);
        wr(7'h00);
        chk(flags[3] == 1, "R4", "write cannot clear watchdog", flags[3], 1);
        step(1);
        chk(irq_n == 0, "R4", "watchdog irq", irq_n, 0);
        fire(7);
        chk(flags[3] == 0, "R4", "reload clears watchdog", flags[3], 0);
        en_wdog = 0;

        // battery-low flag
        cur_req = "R5";
        en_batlow = 1;
        @(negedge clk); batlow_det = 1;
        step(1);
        chk(flags[6] == 1, "R5", "batlow follows detector", flags[6], 1);
        wr(7'h00);
        chk(flags[6] == 1, "R5", "write cannot clear batlow", flags[6], 1);
        batlow_det = 0;
        step(1);
        chk(flags[6] == 0, "R5", "batlow clears with detector", flags[6], 0);
        en_batlow = 0;

        // enables and output-enable
        cur_req = "R9";
        step(2);
        chk(irq_oe == 0, "R9", "oe low with all disabled", irq_oe, 0);
        cur_req = "R10";
        fire(5);
        fire(6);
        fire(2);
        chk(flags[5:4] == 2'b11 && flags[1] == 1, "R10", "flags set while disabled",
            int'(flags), 7'h32);
        step(2);
        chk(irq_n == 1, "R9", "disabled sources do not drive", irq_n, 1);
        cur_req = "R9";
        en_tstamp = 1;
        step(2);
        chk(irq_oe == 1 && irq_n == 0, "R9", "enabled timestamp drives",
            int'({irq_oe, irq_n}), 2);
        wr(7'h00);
        en_tstamp = 0;
        step(3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule